// File: doc/BRIEF.md
# Keyed configuration lock register

This block holds the lock state of a 16-pin I/O port. It provides one lock bit per pin and one key bit. The port's configuration registers use its locked-pin mask output to refuse writes to locked pins. The register sits on a simple register bus with address, write enable, write data, read enable and read data. Read data is combinational, so a read is answered in the same cycle it is issued.

Software writes the pin lock bits freely while the key is inactive. To freeze them, software performs a fixed access sequence on the lock register:

1. A write with the key bit set.
2. A write with the key bit clear.
3. A write with the key bit set.
4. A read.

All three writes must carry the same pin payload. Any deviation abandons the attempt. Once the key is armed, the pin bits and the key stay frozen until reset.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset, a read of the lock register (address LOCK_ADDR, default 7) returns 0, and `locked_mask_o` is 0.
- R2: While the key is inactive, every write to the lock register stores `wdata_i[15:0]` as the pin lock bits. Reads return them in `rdata_o[15:0]`. `rdata_o[31:17]` always reads 0. Reads of other addresses return 0, and writes to other addresses change nothing.
- R3: The key is armed by this sequence of lock-register accesses: write with bit 16 = 1, write with bit 16 = 0, write with bit 16 = 1, then a read. The completing read still returns bit 16 = 0, and every later read returns bit 16 = 1.
- R4: If bits 15:0 of any sequence write differ from those of the first write, the attempt is aborted and the key stays inactive.
- R5: Any lock-register access out of order aborts the attempt. This covers a read before the third write, a wrong key bit value, and a write where the read is expected.
- R6: Once the key is armed, writes to the lock register change neither the pin bits nor the key until reset.
- R7: `locked_mask_o` equals the pin lock bits while the key is armed, and is 0 otherwise.
- R8: Accesses to other addresses between sequence steps neither abort nor advance the sequence.
- R9: An aborting access returns the checker to idle without starting a new attempt. Only a later write with bit 16 = 1 starts step one.
- R10: A direct write with bit 16 = 1 never sets the key bit by itself.
- R11: An access with `we_i` and `re_i` both high counts as a write for the sequence. Its read data is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | DATA_W | Read data, same cycle |
| locked_mask_o | output | NPINS | Locked-pin mask |

## Verification
Two functions can fall into the same cycle.

- **Completing read against a write.** The read that completes the sequence can coincide with a write on the same bus cycle. The bench issues a combined write-and-read at the final step and expects the attempt to abort, because the access counts as a write.
- **Pin update against a sequence step.** Each sequence write also updates the pin bits. The bench judges both effects on the following read and on the mask, and compares them against a bench model run over random mixes of keyed writes, payload changes and foreign-address accesses.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ONE,
    SEQ_ZERO,
    SEQ_WAIT_RD
  } seq_state_e;
endpackage

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             key_i,
  input  logic             wkey_i,
  input  logic [NPINS-1:0] wpins_i,
  output logic             arm_o
);
  seq_state_e st_q, st_d;
  logic [NPINS-1:0] pay_q, pay_d;
  logic same_pay;

  assign same_pay = (wpins_i == pay_q);

  always_comb begin
    st_d  = st_q;
    pay_d = pay_q;
    arm_o = 1'b0;
    if (key_i) begin
      st_d = SEQ_IDLE;
    end else if (wr_i) begin
      unique case (st_q)
        SEQ_IDLE: if (wkey_i) begin
          st_d  = SEQ_ONE;
          pay_d = wpins_i;
        end
        SEQ_ONE:  st_d = (!wkey_i && same_pay) ? SEQ_ZERO : SEQ_IDLE;
        SEQ_ZERO: st_d = (wkey_i && same_pay) ? SEQ_WAIT_RD : SEQ_IDLE;
        default:  st_d = SEQ_IDLE;
      endcase
    end else if (rd_i) begin
      arm_o = (st_q == SEQ_WAIT_RD);
      st_d  = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      pay_q <= '0;
    end else begin
      st_q  <= st_d;
      pay_q <= pay_d;
    end
  end
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NPINS-1:0] wpins_i,
  input  logic             arm_i,
  output logic [NPINS-1:0] pins_o,
  output logic             key_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= '0;
      key_o  <= 1'b0;
    end else if (!key_o) begin
      if (wr_i)  pins_o <= wpins_i;
      if (arm_i) key_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NPINS     = 16,
  parameter int LOCK_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NPINS-1:0]  locked_mask_o
);
  localparam int KEY_BIT = NPINS;
  localparam int PAD_W   = DATA_W - NPINS - 1;
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  logic hit, wr_hit, rd_hit, arm, key_q;
  logic [NPINS-1:0] pins_q;
  logic unused_hi;

  assign hit       = (addr_i == LOCK_A);
  assign wr_hit    = we_i && hit;
  assign rd_hit    = re_i && !we_i && hit; // write wins on a combined access
  assign unused_hi = ^wdata_i[DATA_W-1:KEY_BIT];

  cfg_lock_seq #(.NPINS(NPINS)) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_hit),
    .rd_i    (rd_hit),
    .key_i   (key_q),
    .wkey_i  (wdata_i[KEY_BIT]),
    .wpins_i (wdata_i[NPINS-1:0]),
    .arm_o   (arm)
  );

  cfg_lock_store #(.NPINS(NPINS)) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_hit),
    .wpins_i (wdata_i[NPINS-1:0]),
    .arm_i   (arm),
    .pins_o  (pins_q),
    .key_o   (key_q)
  );

  assign rdata_o = (re_i && hit) ? {{PAD_W{1'b0}}, key_q, pins_q} : '0;

  for (genvar g = 0; g < NPINS; g++) begin : g_mask
    assign locked_mask_o[g] = pins_q[g] & key_q;
  end
endmodule

// File: rtl/cfg_lock_reg_chk.sv
module cfg_lock_reg_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NPINS     = 16,
  parameter int LOCK_ADDR = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NPINS-1:0]  locked_mask_o,
  input logic              key_i
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  AST_KEY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_i |=> key_i); // R6

  AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_i |=> $stable(locked_mask_o)); // R6

  AST_ARM_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_i) |-> $past(re_i && !we_i && addr_i == LOCK_A)); // R3

  AST_MASK_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == LOCK_A && |locked_mask_o) |-> rdata_o[NPINS]); // R7

  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != LOCK_A) |-> (rdata_o == '0)); // R2
endmodule

bind cfg_lock_reg cfg_lock_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPINS(NPINS), .LOCK_ADDR(LOCK_ADDR)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .we_i          (we_i),
  .re_i          (re_i),
  .rdata_o       (rdata_o),
  .locked_mask_o (locked_mask_o),
  .key_i         (key_q)
);

// File: tb/cfg_lock_reg_tb_top.sv
module cfg_lock_reg_tb_top;
  localparam int LA = 7;
  logic clk = 0, rst_ni = 0;
  logic [3:0] addr = 0;
  logic we = 0, re = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] mask;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit m_key;
  logic [15:0] m_pins, m_pay;
  int m_st;

  always #10 clk = ~clk;

  cfg_lock_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .locked_mask_o(mask)
  );

  function automatic logic [31:0] exp_rd(logic [3:0] a, logic r);
    return (r && a == LA) ? {15'd0, m_key, m_pins} : 32'd0;
  endfunction

  function automatic void model_step(logic [3:0] a, logic w, logic r, logic [31:0] d);
    if (m_key || a != LA) return;
    if (w) begin
      m_pins = d[15:0];
      case (m_st)
        0: if (d[16]) begin m_st = 1; m_pay = d[15:0]; end
        1: m_st = (!d[16] && d[15:0] == m_pay) ? 2 : 0;
        2: m_st = (d[16] && d[15:0] == m_pay) ? 3 : 0;
        default: m_st = 0;
      endcase
    end else if (r) begin
      if (m_st == 3) m_key = 1;
      m_st = 0;
    end
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; we = 0; re = 0;
    m_key = 0; m_pins = 0; m_pay = 0; m_st = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic op(string tag, logic [3:0] a, logic w, logic r, logic [31:0] d);
    @(negedge clk);
    addr = a; we = w; re = r; wdata = d;
    #1;
    chk({tag, " rdata"}, rdata, exp_rd(a, r));
    chk({tag, " mask"}, {16'd0, mask}, {16'd0, m_pins & {16{m_key}}});
    @(posedge clk);
    model_step(a, w, r, d);
    #1;
    we = 0; re = 0;
  endtask

  task automatic wr(string t, logic [31:0] d); op(t, 4'(LA), 1, 0, d); endtask
  task automatic rd(string t); op(t, 4'(LA), 0, 1, 0); endtask

  initial begin
    #1 do_reset();
    rd("R1");
    // R2 pins and unused upper bits
    wr("R2", 32'hFFFE_00A5);
    rd("R2");
    op("R2", 4'd3, 1, 0, 32'h0001_FFFF);
    op("R2", 4'd3, 0, 1, 0);
    rd("R2");
    // R10 direct key write
    wr("R10", 32'h0001_1234);
    rd("R10");
    // R3 with R8 foreign accesses between steps
    wr("R3", 32'h0001_C33C);
    op("R8", 4'd2, 0, 1, 0);
    wr("R3", 32'h0000_C33C);
    op("R8", 4'd5, 1, 0, 32'h0001_0000);
    wr("R3", 32'h0001_C33C);
    rd("R3");
    rd("R3");
    chk("R3 key", {31'd0, m_key}, 32'd1);
    chk("R7 mask armed", {16'd0, mask}, 32'h0000_C33C);
    // R6 writes ignored when armed
    wr("R6", 32'h0000_0000);
    wr("R6", 32'h0001_FFFF);
    rd("R6");
    do_reset();
    rd("R1");
    // R4 payload change
    wr("R4", 32'h0001_0F0F);
    wr("R4", 32'h0000_0F0E);
    wr("R4", 32'h0001_0F0F);
    rd("R4"); rd("R4");
    // R5 early read
    wr("R5", 32'h0001_0001);
    wr("R5", 32'h0000_0001);
    rd("R5");
    wr("R5", 32'h0001_0001);
    rd("R5"); rd("R5");
    // R5 write where read expected
    wr("R5", 32'h0001_0002);
    wr("R5", 32'h0000_0002);
    wr("R5", 32'h0001_0002);
    wr("R5", 32'h0001_0002);
    rd("R5"); rd("R5");
    // R9 aborting write does not restart
    wr("R9", 32'h0001_0003);
    wr("R9", 32'h0001_0003);
    wr("R9", 32'h0000_0003);
    wr("R9", 32'h0001_0003);
    rd("R9"); rd("R9");
    // R11 combined write and read at final step
    wr("R11", 32'h0001_0004);
    wr("R11", 32'h0000_0004);
    wr("R11", 32'h0001_0004);
    op("R11", 4'(LA), 1, 1, 32'h0001_0004);
    rd("R11"); rd("R11");
    chk("R11 key", {31'd0, m_key}, 32'd0);
    chk("R7 mask unarmed", {16'd0, mask}, 32'd0);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [31:0] d;
      if (i % 60 == 0) do_reset();
      sel = $urandom_range(0, 9);
      d = {$urandom_range(0, 3) == 0 ? 15'h7FFF : 15'd0, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0) ? 16'h5A5B : 16'h5A5A};
      if (sel < 5)      wr("R3 rnd", d);
      else if (sel < 8) rd("R5 rnd");
      else if (sel < 9) op("R8 rnd", 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                           1'($urandom_range(0, 1)), d);
      else              op("R11 rnd", 4'(LA), 1, 1, d);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule